// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns an addressing request into a 20-bit physical memory address. It forms a 16-bit effective offset from base registers, index registers, an optional displacement, the instruction pointer or a direct offset, according to the selected addressing mode. It then picks the segment register that belongs to that mode and adds the segment value, shifted left by four bits, to the offset.

The block is a two-stage pipeline. The first stage computes the effective address and selects the segment. The second stage adds the scaled segment base to the offset. A request presented with `valid_i` high appears at the outputs two clock edges later, together with the offset used and the identity of the chosen segment. The caller supplies the decoded mode and the register values. Instruction decode, segment overrides and the memory bus cycle are handled elsewhere.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `ea_o`, `seg_id_o` and `phys_o` are all zero, whatever the inputs do.
- R2: `valid_o` equals `valid_i` from two rising edges earlier for modes 0 to 6. A request with reserved mode 7 never raises `valid_o`.
- R3: Mode 0 (fetch) uses `ip_i` as the offset and the code segment (`seg_id_o` = 0).
- R4: Mode 1 (direct) uses the full 16-bit `disp_i` as the offset and the data segment (`seg_id_o` = 1). `disp_size_i` has no effect in this mode.
- R5: Mode 2 (register indirect) takes the offset from BX, BP, SI or DI for `reg_sel_i` = 0, 1, 2 or 3. It uses the stack segment (`seg_id_o` = 2) for BP and the data segment for the others.
- R6: Mode 3 (based) adds BX (`base_sel_i` = 0) or BP (`base_sel_i` = 1) to the displacement. It uses the stack segment for BP and the data segment for BX.
- R7: Mode 4 (indexed) adds SI (`idx_sel_i` = 0) or DI (`idx_sel_i` = 1) to the displacement and uses the data segment.
- R8: Mode 5 (based-indexed) adds the selected base, the selected index and the displacement. It picks the segment by base register as in R6.
- R9: In modes 3 to 5, `disp_size_i` = 0 means no displacement. A value of 1 means `disp_i[7:0]` sign-extended to 16 bits, with `disp_i[15:8]` ignored. A value of 2 or 3 means the full 16-bit `disp_i`.
- R10: Mode 6 (string destination) uses DI as the offset and the extra segment (`seg_id_o` = 3).
- R11: The effective-address sum wraps modulo 2^16.
- R12: `phys_o` = (segment × 16 + `ea_o`) mod 2^20, so `phys_o[3:0]` always equals `ea_o[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present |
| mode_i | input | 3 | Addressing mode, 0 to 6; 7 is reserved |
| reg_sel_i | input | 2 | Indirect register: 0 BX, 1 BP, 2 SI, 3 DI |
| base_sel_i | input | 1 | Base register: 0 BX, 1 BP |
| idx_sel_i | input | 1 | Index register: 0 SI, 1 DI |
| disp_size_i | input | 2 | 0 none, 1 signed byte, 2/3 word |
| disp_i | input | 16 | Displacement or direct offset |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| ip_i | input | 16 | Instruction pointer |
| cs_i | input | 16 | Code segment value |
| ds_i | input | 16 | Data segment value |
| ss_i | input | 16 | Stack segment value |
| es_i | input | 16 | Extra segment value |
| valid_o | output | 1 | Result present |
| ea_o | output | 16 | Effective offset used |
| seg_id_o | output | 2 | Segment used: 0 code, 1 data, 2 stack, 3 extra |
| phys_o | output | 20 | Physical address |

## Verification
If the wrong segment is chosen, both `seg_id_o` and `phys_o` are wrong on the same result. A bad operand select, a missing sign extension or a carry out of the offset adder shows up in `ea_o` and in the low nibble of `phys_o`. All of these errors appear exactly two edges after the request. If the valid pipeline is broken, `valid_o` shifts against the data or a reserved request is let through, and this is visible on the first affected cycle. The bench compares every output field on every cycle against a behavioural model, so any such error is caught within two cycles of the request that exposes it.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [2:0] {
    AM_FETCH    = 3'd0,
    AM_DIRECT   = 3'd1,
    AM_INDIRECT = 3'd2,
    AM_BASED    = 3'd3,
    AM_INDEXED  = 3'd4,
    AM_BASE_IDX = 3'd5,
    AM_STR_DST  = 3'd6,
    AM_RSVD     = 3'd7
  } addr_mode_e;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    DSP_NONE = 2'd0,
    DSP_BYTE = 2'd1,
    DSP_WORD = 2'd2,
    DSP_WALT = 2'd3
  } disp_size_e;
endpackage

// File: rtl/sag_ea_calc.sv
module sag_ea_calc
  import seg_addr_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int DSP_B_W = 8
) (
  input  addr_mode_e       mode_i,
  input  logic [1:0]       reg_sel_i,
  input  logic             base_sel_i,
  input  logic             idx_sel_i,
  input  disp_size_e       disp_size_i,
  input  logic [OFS_W-1:0] disp_i,
  input  logic [OFS_W-1:0] bx_i,
  input  logic [OFS_W-1:0] bp_i,
  input  logic [OFS_W-1:0] si_i,
  input  logic [OFS_W-1:0] di_i,
  input  logic [OFS_W-1:0] ip_i,
  output logic [OFS_W-1:0] ea_o,
  output logic             uses_bp_o,
  output logic             legal_o
);
  logic [OFS_W-1:0] disp_sx;
  logic [OFS_W-1:0] disp_ext;
  logic [OFS_W-1:0] base_val, idx_val;
  logic [OFS_W-1:0] op_a, op_b, op_c;

  generate
    if (DSP_B_W < OFS_W) begin : g_sext
      assign disp_sx = {{(OFS_W-DSP_B_W){disp_i[DSP_B_W-1]}}, disp_i[DSP_B_W-1:0]};
    end else begin : g_nosext
      assign disp_sx = disp_i;
    end
  endgenerate

  always_comb begin
    unique case (disp_size_i)
      DSP_NONE: disp_ext = '0;
      DSP_BYTE: disp_ext = disp_sx;
      default:  disp_ext = disp_i;
    endcase
  end

  assign base_val = base_sel_i ? bp_i : bx_i;
  assign idx_val  = idx_sel_i  ? di_i : si_i;

  always_comb begin
    op_a      = '0;
    op_b      = '0;
    op_c      = '0;
    uses_bp_o = 1'b0;
    legal_o   = 1'b1;
    unique case (mode_i)
      AM_FETCH:  op_a = ip_i;
      AM_DIRECT: op_a = disp_i;
      AM_INDIRECT: begin
        unique case (reg_sel_i)
          2'd0: op_a = bx_i;
          2'd1: begin op_a = bp_i; uses_bp_o = 1'b1; end
          2'd2: op_a = si_i;
          default: op_a = di_i;
        endcase
      end
      AM_BASED: begin
        op_a      = base_val;
        op_c      = disp_ext;
        uses_bp_o = base_sel_i;
      end
      AM_INDEXED: begin
        op_b = idx_val;
        op_c = disp_ext;
      end
      AM_BASE_IDX: begin
        op_a      = base_val;
        op_b      = idx_val;
        op_c      = disp_ext;
        uses_bp_o = base_sel_i;
      end
      AM_STR_DST: op_a = di_i;
      default: legal_o = 1'b0;
    endcase
  end

  // single three-input adder, wraps at OFS_W bits
  assign ea_o = op_a + op_b + op_c;
endmodule

// File: rtl/sag_seg_sel.sv
module sag_seg_sel
  import seg_addr_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int NUM_SEG = 4
) (
  input  addr_mode_e                    mode_i,
  input  logic                          uses_bp_i,
  input  logic [NUM_SEG-1:0][SEG_W-1:0] seg_vals_i,
  output seg_id_e                       seg_id_o,
  output logic [SEG_W-1:0]              seg_val_o
);
  always_comb begin
    unique case (mode_i)
      AM_FETCH:   seg_id_o = SEG_CODE;
      AM_STR_DST: seg_id_o = SEG_EXTRA;
      default:    seg_id_o = uses_bp_i ? SEG_STACK : SEG_DATA;
    endcase
  end

  assign seg_val_o = seg_vals_i[seg_id_o];
endmodule

// File: rtl/sag_phys_add.sv
module sag_phys_add #(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [PA_W-1:0]  phys_o
);
  assign phys_o = {seg_i, {SHIFT{1'b0}}} + {{(PA_W-OFS_W){1'b0}}, ofs_i};
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int SEG_W   = 16,
  parameter int SHIFT   = 4,
  parameter int DSP_B_W = 8,
  localparam int PA_W   = SEG_W + SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       reg_sel_i,
  input  logic             base_sel_i,
  input  logic             idx_sel_i,
  input  logic [1:0]       disp_size_i,
  input  logic [OFS_W-1:0] disp_i,
  input  logic [OFS_W-1:0] bx_i,
  input  logic [OFS_W-1:0] bp_i,
  input  logic [OFS_W-1:0] si_i,
  input  logic [OFS_W-1:0] di_i,
  input  logic [OFS_W-1:0] ip_i,
  input  logic [SEG_W-1:0] cs_i,
  input  logic [SEG_W-1:0] ds_i,
  input  logic [SEG_W-1:0] ss_i,
  input  logic [SEG_W-1:0] es_i,
  output logic             valid_o,
  output logic [OFS_W-1:0] ea_o,
  output logic [1:0]       seg_id_o,
  output logic [PA_W-1:0]  phys_o
);
  localparam int NUM_SEG = 4;

  addr_mode_e mode;
  logic [OFS_W-1:0] ea_c;
  logic uses_bp_c, legal_c;
  seg_id_e seg_id_c;
  logic [SEG_W-1:0] seg_val_c;
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_vals;

  logic             s1_valid;
  addr_mode_e       s1_mode;
  logic [OFS_W-1:0] s1_ea;
  seg_id_e          s1_seg_id;
  logic [SEG_W-1:0] s1_seg_val;
  addr_mode_e       s2_mode;
  logic [PA_W-1:0]  phys_c;

  assign mode = addr_mode_e'(mode_i);
  assign seg_vals[SEG_CODE]  = cs_i;
  assign seg_vals[SEG_DATA]  = ds_i;
  assign seg_vals[SEG_STACK] = ss_i;
  assign seg_vals[SEG_EXTRA] = es_i;

  sag_ea_calc #(.OFS_W(OFS_W), .DSP_B_W(DSP_B_W)) u_ea (
    .mode_i      (mode),
    .reg_sel_i   (reg_sel_i),
    .base_sel_i  (base_sel_i),
    .idx_sel_i   (idx_sel_i),
    .disp_size_i (disp_size_e'(disp_size_i)),
    .disp_i      (disp_i),
    .bx_i        (bx_i),
    .bp_i        (bp_i),
    .si_i        (si_i),
    .di_i        (di_i),
    .ip_i        (ip_i),
    .ea_o        (ea_c),
    .uses_bp_o   (uses_bp_c),
    .legal_o     (legal_c)
  );

  sag_seg_sel #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_seg (
    .mode_i     (mode),
    .uses_bp_i  (uses_bp_c),
    .seg_vals_i (seg_vals),
    .seg_id_o   (seg_id_c),
    .seg_val_o  (seg_val_c)
  );

  // stage 1: offset and segment choice
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid   <= 1'b0;
      s1_mode    <= AM_FETCH;
      s1_ea      <= '0;
      s1_seg_id  <= SEG_CODE;
      s1_seg_val <= '0;
    end else begin
      s1_valid   <= valid_i && legal_c;
      s1_mode    <= mode;
      s1_ea      <= ea_c;
      s1_seg_id  <= seg_id_c;
      s1_seg_val <= seg_val_c;
    end
  end

  sag_phys_add #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) u_pa (
    .seg_i  (s1_seg_val),
    .ofs_i  (s1_ea),
    .phys_o (phys_c)
  );

  // stage 2: physical address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      s2_mode  <= AM_FETCH;
      ea_o     <= '0;
      seg_id_o <= 2'd0;
      phys_o   <= '0;
    end else begin
      valid_o  <= s1_valid;
      s2_mode  <= s1_mode;
      ea_o     <= s1_ea;
      seg_id_o <= s1_seg_id;
      phys_o   <= phys_c;
    end
  end

  // R12
  phys_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> phys_o[SHIFT-1:0] == ea_o[SHIFT-1:0]);

  // R3
  fetch_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && s2_mode == AM_FETCH) |-> seg_id_o == 2'(SEG_CODE));

  // R2
  rsvd_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 3'd7) |=> !s1_valid);

  // R10
  str_extra_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_mode == AM_STR_DST) |-> s1_seg_id == SEG_EXTRA);

  // R7
  idx_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_mode == AM_INDEXED) |-> s1_seg_id == SEG_DATA);
endmodule

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        valid_i;
  logic [2:0]  mode_i;
  logic [1:0]  reg_sel_i;
  logic        base_sel_i, idx_sel_i;
  logic [1:0]  disp_size_i;
  logic [15:0] disp_i, bx_i, bp_i, si_i, di_i, ip_i, cs_i, ds_i, ss_i, es_i;
  logic        valid_o;
  logic [15:0] ea_o;
  logic [1:0]  seg_id_o;
  logic [19:0] phys_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit    q_v[$];
  int    q_ea[$], q_seg[$], q_pa[$];
  string q_tag[$];

  seg_addr_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .reg_sel_i(reg_sel_i), .base_sel_i(base_sel_i), .idx_sel_i(idx_sel_i),
    .disp_size_i(disp_size_i), .disp_i(disp_i), .bx_i(bx_i), .bp_i(bp_i),
    .si_i(si_i), .di_i(di_i), .ip_i(ip_i), .cs_i(cs_i), .ds_i(ds_i),
    .ss_i(ss_i), .es_i(es_i), .valid_o(valid_o), .ea_o(ea_o),
    .seg_id_o(seg_id_o), .phys_o(phys_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model of the current inputs, pushed as the expected result
  task automatic push_model();
    int dext, raw, off, sid, segv, pa_raw, base, idx;
    bit v;
    string tag;
    v = valid_i;
    dext = (disp_size_i == 2'd0) ? 0 :
           (disp_size_i == 2'd1) ? ((disp_i[7] ? 32'(disp_i[7:0]) - 256 : 32'(disp_i[7:0])))
                                 : 32'(disp_i);
    base = base_sel_i ? 32'(bp_i) : 32'(bx_i);
    idx  = idx_sel_i ? 32'(di_i) : 32'(si_i);
    raw = 0; sid = 1;
    case (mode_i)
      3'd0: begin raw = 32'(ip_i); sid = 0; tag = "R3"; end
      3'd1: begin raw = 32'(disp_i); sid = 1; tag = "R4"; end
      3'd2: begin
        case (reg_sel_i)
          2'd0: raw = 32'(bx_i);
          2'd1: raw = 32'(bp_i);
          2'd2: raw = 32'(si_i);
          default: raw = 32'(di_i);
        endcase
        sid = (reg_sel_i == 2'd1) ? 2 : 1; tag = "R5";
      end
      3'd3: begin raw = base + dext; sid = base_sel_i ? 2 : 1; tag = "R6"; end
      3'd4: begin raw = idx + dext; sid = 1; tag = "R7"; end
      3'd5: begin raw = base + idx + dext; sid = base_sel_i ? 2 : 1; tag = "R8"; end
      3'd6: begin raw = 32'(di_i); sid = 3; tag = "R10"; end
      default: begin v = 0; tag = "R2"; end
    endcase
    if (mode_i inside {3'd3, 3'd4, 3'd5} && disp_size_i == 2'd1) tag = "R9";
    if (raw < 0 || raw > 65535) tag = "R11";
    off = ((raw % 65536) + 65536) % 65536;
    segv = (sid == 0) ? 32'(cs_i) : (sid == 1) ? 32'(ds_i) : (sid == 2) ? 32'(ss_i) : 32'(es_i);
    pa_raw = segv * 16 + off;
    if (pa_raw > 20'hFFFFF) tag = "R12";
    if (!valid_i) tag = "R2";
    q_v.push_back(v); q_ea.push_back(off); q_seg.push_back(sid);
    q_pa.push_back(pa_raw % 1048576); q_tag.push_back(tag);
  endtask

  task automatic check_head();
    bit v; int e, s, p; string t;
    if (q_v.size() < 2) return;
    v = q_v.pop_front(); e = q_ea.pop_front(); s = q_seg.pop_front();
    p = q_pa.pop_front(); t = q_tag.pop_front();
    if (valid_o !== v) chk(0, v ? t : "R2", 32'(valid_o), 32'(v));
    else if (!v) chk(1, "R2", 0, 0);
    else if (32'(ea_o) != e) chk(0, t, 32'(ea_o), e);
    else if (32'(seg_id_o) != s) chk(0, t, 32'(seg_id_o), s);
    else if (32'(phys_o) != p) chk(0, (t == "R12") ? t : {t, "/R12"}, 32'(phys_o), p);
    else chk(1, t, 0, 0);
  endtask

  task automatic step(input bit v, input logic [2:0] m, input logic [1:0] rs,
                      input bit bs, input bit is, input logic [1:0] dsz,
                      input logic [15:0] dp, input logic [15:0] bx, input logic [15:0] bp,
                      input logic [15:0] si, input logic [15:0] di, input logic [15:0] ip,
                      input logic [15:0] cs, input logic [15:0] ds, input logic [15:0] ss,
                      input logic [15:0] es);
    @(negedge clk);
    check_head();
    valid_i = v; mode_i = m; reg_sel_i = rs; base_sel_i = bs; idx_sel_i = is;
    disp_size_i = dsz; disp_i = dp; bx_i = bx; bp_i = bp; si_i = si; di_i = di;
    ip_i = ip; cs_i = cs; ds_i = ds; ss_i = ss; es_i = es;
    push_model();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    valid_i = 1'b1; mode_i = 3'd0; reg_sel_i = 2'd0; base_sel_i = 1'b0; idx_sel_i = 1'b0;
    disp_size_i = 2'd2; disp_i = 16'h1234; bx_i = 16'h1111; bp_i = 16'h2222;
    si_i = 16'h3333; di_i = 16'h4444; ip_i = 16'h5555;
    cs_i = 16'h1000; ds_i = 16'h2000; ss_i = 16'h3000; es_i = 16'h4000;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset despite valid input
    chk(valid_o == 1'b0, "R1", 32'(valid_o), 0);
    chk(ea_o == 16'h0, "R1", 32'(ea_o), 0);
    chk(seg_id_o == 2'd0, "R1", 32'(seg_id_o), 0);
    chk(phys_o == 20'h0, "R1", 32'(phys_o), 0);
    valid_i = 1'b0;
    rst_n = 1'b1;

    // R3 fetch near top of memory, and R12 wrap past 1 MB
    step(1, 3'd0, 0, 0, 0, 0, 16'h0, 0, 0, 0, 0, 16'hFFF0, 16'hF000, 16'h0, 16'h0, 16'h0);
    step(1, 3'd0, 0, 0, 0, 0, 16'h0, 0, 0, 0, 0, 16'h0020, 16'hFFFF, 16'h0, 16'h0, 16'h0);
    // R4 direct ignores displacement size
    step(1, 3'd1, 0, 0, 0, 2'd1, 16'h0301, 0, 0, 0, 0, 0, 16'h1, 16'h2000, 16'h3, 16'h4);
    // R5 each indirect register
    for (int r = 0; r < 4; r++)
      step(1, 3'd2, 2'(r), 0, 0, 0, 16'h0, 16'h0100, 16'h0200, 16'h0300, 16'h0400, 0,
           16'h1000, 16'h2000, 16'h3000, 16'h4000);
    // R6 based via BP with word disp
    step(1, 3'd3, 0, 1, 0, 2'd2, 16'h1346, 16'h10, 16'h20, 0, 0, 0, 16'h1, 16'h2, 16'h3, 16'h4);
    // R9 byte disp: 0xAB80 -> -128, upper byte ignored
    step(1, 3'd3, 0, 0, 0, 2'd1, 16'hAB80, 16'h0200, 0, 0, 0, 0, 16'h1, 16'h2, 16'h3, 16'h4);
    step(1, 3'd4, 0, 0, 1, 2'd1, 16'hFF05, 0, 0, 16'h50, 16'h60, 0, 16'h1, 16'h2, 16'h3, 16'h4);
    // R7 indexed SI with no disp
    step(1, 3'd4, 0, 0, 0, 2'd0, 16'h7777, 0, 0, 16'h0ABC, 16'h0DEF, 0, 16'h1, 16'h2, 16'h3, 16'h4);
    // R8 based-indexed with and without disp, R11 wrap of effective address
    step(1, 3'd5, 0, 0, 0, 2'd0, 16'h0, 16'h0100, 16'h0, 16'h0010, 0, 0, 16'h1, 16'h2, 16'h3, 16'h4);
    step(1, 3'd5, 0, 1, 1, 2'd2, 16'h1235, 16'h0, 16'h0500, 0, 16'h0030, 0, 16'h1, 16'h2, 16'h3, 16'h4);
    step(1, 3'd5, 0, 0, 0, 2'd2, 16'h0001, 16'hFFFF, 0, 16'h0002, 0, 0, 16'h1, 16'h2, 16'h3, 16'h4);
    // R10 string destination
    step(1, 3'd6, 0, 0, 0, 0, 0, 0, 0, 0, 16'hBEEF, 0, 16'h1, 16'h2, 16'h3, 16'h9000);
    // R2 reserved mode and idle slot
    step(1, 3'd7, 0, 0, 0, 0, 0, 1, 2, 3, 4, 5, 16'h1, 16'h2, 16'h3, 16'h4);
    step(0, 3'd0, 0, 0, 0, 0, 0, 1, 2, 3, 4, 5, 16'h1, 16'h2, 16'h3, 16'h4);

    // random traffic
    for (int n = 0; n < 3000; n++)
      step(($urandom % 8) != 0, 3'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
           16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
           16'($urandom));
    // drain
    repeat (2) step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule